// File: doc/BRIEF.md
# Page Program Data Latch

This block sits between a serial flash front end and the array programmer. When a page-program instruction starts, it records the target page and the starting byte offset. It then gathers incoming data units into bytes and stores each completed byte in a page-sized buffer, marking that offset in a per-byte valid mask. The instruction may arrive in two forms. Opcode 02h sends its data one bit per unit. Opcode 32h sends it four bits per unit.

When chip select rises, the block decides whether to hand the page to the programmer. It issues a commit strobe only if four conditions all hold: the transfer stopped on a byte boundary, at least one byte arrived, the write-enable latch is set, and the protection logic allows writing to the address. After a commit the block reports busy and holds its outputs until the programmer signals completion. Completion then produces a one-cycle pulse that clears the write-enable latch.

The programmer is expected to AND each valid buffer byte into the old array contents, because programming can only clear bits.

Top module: `page_prog_latch`

## Requirements
- R1: After reset, commit_o, busy_o and wel_clr_o are 0 and mask_o is all zeros.
- R2: With opcode 02h, each data unit carries one bit on unit_i[0], most significant bit first. The eighth unit completes a byte, which goes to buf_o[8*offset +: 8] and sets mask_o[offset].
- R3: With opcode 32h, each data unit carries four bits on unit_i[3:0]. The first unit holds data bits 7..4 and the second holds bits 3..0.
- R4: page_o equals address bits 23:8 taken at the start. The byte offset begins at address bits 7:0, rises by one per byte, and wraps from FFh to 00h within the same page.
- R5: When more than 256 bytes arrive, later bytes overwrite earlier ones at the same offset, and every mask bit is set.
- R6: The mask and the offset are reset at every 02h or 32h start. Only offsets that received a byte since the most recent start are marked valid.
- R7: commit_o pulses for one cycle, one cycle after cs_rise_i. This happens only when the bit count is a whole number of bytes, at least one byte arrived, and wel_i and wr_ok_i are both 1. Otherwise no commit occurs.
- R8: busy_o rises together with commit_o and stays high until prog_done_i. On the cycle after prog_done_i, busy_o is 0 and wel_clr_o pulses for one cycle.
- R9: While busy_o is 1, starts, data units and chip-select rises have no effect, and page_o, mask_o and buf_o hold their values.
- R10: A start with any other opcode ends capture. Later data units are then ignored, and a chip-select rise produces no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Instruction start; opcode_i and addr_i are valid |
| opcode_i | input | 8 | Decoded opcode |
| addr_i | input | 24 | Decoded byte address |
| unit_vld_i | input | 1 | One data unit is present on unit_i |
| unit_i | input | 4 | Data unit: bit 0 in one-lane mode, all bits in four-lane mode |
| cs_rise_i | input | 1 | Chip select has just risen |
| wel_i | input | 1 | Write-enable latch state |
| wr_ok_i | input | 1 | Protection logic allows writing to the page |
| prog_done_i | input | 1 | Array programmer has finished |
| commit_o | output | 1 | One-cycle strobe: page handed over |
| busy_o | output | 1 | Programming in progress |
| wel_clr_o | output | 1 | One-cycle pulse that clears the write-enable latch |
| page_o | output | 16 | Page base (address bits 23:8) |
| buf_o | output | 2048 | Page buffer; byte k is at bits 8k+7..8k |
| mask_o | output | 256 | Valid mask, one bit per byte |

## Verification
All results are registered once.

- commit_o and busy_o appear on the edge at which cs_rise_i is sampled.
- wel_clr_o and the fall of busy_o appear on the edge at which prog_done_i is sampled.
- A byte's mask bit and buffer contents are updated on the edge that takes in its last unit.

The bench drives inputs at the falling edge and samples one falling edge after the rising edge that consumed the stimulus, so every check looks at exactly the cycle in which its result first becomes valid.

// File: rtl/page_prog_latch.sv
module page_prog_latch #(
  parameter int ADDR_W = 24,
  parameter int PAGE_BYTES = 256,
  parameter logic [7:0] OP_ONE = 8'h02,
  parameter logic [7:0] OP_FOUR = 8'h32,
  localparam int OFS_W = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFS_W,
  localparam int BUF_W = PAGE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              unit_vld_i,
  input  logic [3:0]        unit_i,
  input  logic              cs_rise_i,
  input  logic              wel_i,
  input  logic              wr_ok_i,
  input  logic              prog_done_i,
  output logic              commit_o,
  output logic              busy_o,
  output logic              wel_clr_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [BUF_W-1:0]  buf_o,
  output logic [PAGE_BYTES-1:0] mask_o
);

  logic             active, quad, got;
  logic [2:0]       bcnt;
  logic [7:0]       sh;
  logic [OFS_W-1:0] ptr;

  wire [7:0] nxt_sh  = quad ? {sh[3:0], unit_i} : {sh[6:0], unit_i[0]};
  wire [3:0] nxt_cnt = {1'b0, bcnt} + (quad ? 4'd4 : 4'd1);
  wire       is_pp   = (opcode_i == OP_ONE) || (opcode_i == OP_FOUR);
  wire       take    = !busy_o && !start_i && !cs_rise_i && unit_vld_i && active;
  wire       byte_done = take && nxt_cnt[3];
  wire       fire    = active && (bcnt == 3'd0) && got && wel_i && wr_ok_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      quad      <= 1'b0;
      got       <= 1'b0;
      bcnt      <= '0;
      sh        <= '0;
      ptr       <= '0;
      page_o    <= '0;
      mask_o    <= '0;
      commit_o  <= 1'b0;
      busy_o    <= 1'b0;
      wel_clr_o <= 1'b0;
    end else begin
      commit_o  <= 1'b0;
      wel_clr_o <= 1'b0;
      if (busy_o) begin
        if (prog_done_i) begin
          busy_o    <= 1'b0;
          wel_clr_o <= 1'b1;
        end
      end else if (start_i) begin
        active <= is_pp;
        quad   <= (opcode_i == OP_FOUR);
        page_o <= addr_i[ADDR_W-1:OFS_W];
        ptr    <= addr_i[OFS_W-1:0];
        mask_o <= '0;
        got    <= 1'b0;
        bcnt   <= '0;
        sh     <= '0;
      end else if (cs_rise_i) begin
        active <= 1'b0;
        if (fire) begin
          commit_o <= 1'b1;
          busy_o   <= 1'b1;
        end
      end else if (take) begin
        sh   <= nxt_sh;
        bcnt <= nxt_cnt[2:0];
        if (nxt_cnt[3]) begin
          mask_o[ptr] <= 1'b1;
          ptr         <= ptr + 1'b1;
          got         <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (byte_done) buf_o[{ptr, 3'b000} +: 8] <= nxt_sh;
  end

endmodule

module page_prog_latch_chk #(
  parameter int PAGE_W = 16,
  parameter int PAGE_BYTES = 256
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_rise_i,
  input logic                  wel_i,
  input logic                  wr_ok_i,
  input logic                  prog_done_i,
  input logic                  commit_o,
  input logic                  busy_o,
  input logic                  wel_clr_o,
  input logic [PAGE_W-1:0]     page_o,
  input logic [PAGE_BYTES-1:0] mask_o
);

  a_r7_commit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> ($past(cs_rise_i) && $past(wel_i) && $past(wr_ok_i)));

  a_r7_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (mask_o != '0));

  a_r8_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (busy_o && !$past(busy_o)));

  a_r8_busy_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && prog_done_i) |=> (!busy_o && wel_clr_o));

  a_r8_wel_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr_o |-> (!busy_o && $past(busy_o) && $past(prog_done_i)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(mask_o) && $stable(page_o)));

endmodule

bind page_prog_latch page_prog_latch_chk #(.PAGE_W(PAGE_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise_i(cs_rise_i), .wel_i(wel_i), .wr_ok_i(wr_ok_i),
  .prog_done_i(prog_done_i), .commit_o(commit_o), .busy_o(busy_o),
  .wel_clr_o(wel_clr_o), .page_o(page_o), .mask_o(mask_o)
);

// File: tb/test_page_prog_latch.sv
`timescale 1ns/1ps
module test_page_prog_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] opcode_i = '0;
  logic [23:0] addr_i = '0;
  logic unit_vld_i = 1'b0;
  logic [3:0] unit_i = '0;
  logic cs_rise_i = 1'b0;
  logic wel_i = 1'b0;
  logic wr_ok_i = 1'b0;
  logic prog_done_i = 1'b0;
  logic commit_o, busy_o, wel_clr_o;
  logic [15:0] page_o;
  logic [2047:0] buf_o;
  logic [255:0] mask_o;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  page_prog_latch i_page_prog_latch (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i), .addr_i(addr_i),
    .unit_vld_i(unit_vld_i), .unit_i(unit_i), .cs_rise_i(cs_rise_i), .wel_i(wel_i),
    .wr_ok_i(wr_ok_i), .prog_done_i(prog_done_i), .commit_o(commit_o), .busy_o(busy_o),
    .wel_clr_o(wel_clr_o), .page_o(page_o), .buf_o(buf_o), .mask_o(mask_o)
  );

  // {quad, addr[23:0], nbytes[8:0], seed[7:0], wel, wr_ok, expect_commit}
  localparam logic [44:0] VEC [8] = '{
    {1'b0, 24'h123410, 9'd4,   8'h5A, 1'b1, 1'b1, 1'b1},
    {1'b1, 24'hABCD20, 9'd3,   8'h11, 1'b1, 1'b1, 1'b1},
    {1'b0, 24'h0007FE, 9'd5,   8'h80, 1'b1, 1'b1, 1'b1},
    {1'b1, 24'h3F0000, 9'd256, 8'h33, 1'b1, 1'b1, 1'b1},
    {1'b1, 24'h2000F0, 9'd260, 8'h77, 1'b1, 1'b1, 1'b1},
    {1'b0, 24'h000040, 9'd2,   8'h01, 1'b0, 1'b1, 1'b0},
    {1'b1, 24'h000040, 9'd2,   8'h01, 1'b1, 1'b0, 1'b0},
    {1'b0, 24'h000040, 9'd0,   8'h00, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic begin_op(input logic [7:0] op, input logic [23:0] a);
    start_i = 1'b1; opcode_i = op; addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send_byte(input logic q, input logic [7:0] b);
    unit_vld_i = 1'b1;
    if (q) begin
      unit_i = b[7:4]; @(negedge clk);
      unit_i = b[3:0]; @(negedge clk);
    end else begin
      for (int i = 7; i >= 0; i--) begin
        unit_i = {3'b000, b[i]}; @(negedge clk);
      end
    end
    unit_vld_i = 1'b0;
  endtask

  task automatic end_op();
    cs_rise_i = 1'b1;
    @(negedge clk);
    cs_rise_i = 1'b0;
  endtask

  task automatic release_prog();
    prog_done_i = 1'b1;
    @(negedge clk);
    prog_done_i = 1'b0;
    check("R8 busy falls", {255'd0, busy_o}, 256'd0);
    check("R8 wel_clr pulse", {255'd0, wel_clr_o}, 256'd1);
    @(negedge clk);
    check("R8 wel_clr one cycle", {255'd0, wel_clr_o}, 256'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] exp_b [256];
    logic [255:0] exp_m;
    logic [15:0] pg_hold;
    logic [255:0] m_hold;
    repeat (3) @(negedge clk);
    check("R1 commit", {255'd0, commit_o}, 256'd0);
    check("R1 busy", {255'd0, busy_o}, 256'd0);
    check("R1 wel_clr", {255'd0, wel_clr_o}, 256'd0);
    check("R1 mask", mask_o, 256'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      logic q, ec;
      logic [23:0] a;
      int n, bad;
      logic [7:0] seed;
      q = VEC[v][44]; a = VEC[v][43:20]; n = int'(VEC[v][19:11]); seed = VEC[v][10:3];
      wel_i = VEC[v][2]; wr_ok_i = VEC[v][1]; ec = VEC[v][0];
      exp_m = '0;
      begin_op(q ? 8'h32 : 8'h02, a);
      for (int k = 0; k < n; k++) begin
        logic [7:0] o, d;
        o = a[7:0] + 8'(k);
        d = seed + 8'(k * 37);
        exp_b[o] = d;
        exp_m[o] = 1'b1;
        send_byte(q, d);
      end
      end_op();
      check("R7 commit decision", {255'd0, commit_o}, {255'd0, ec});
      if (ec) begin
        check("R8 busy with commit", {255'd0, busy_o}, 256'd1);
        check("R4 page base", {240'd0, page_o}, {240'd0, a[23:8]});
        check(n >= 256 ? "R5 full mask" : "R6 mask offsets with R4 wrap", mask_o, exp_m);
        bad = 0;
        for (int o = 0; o < 256; o++)
          if (exp_m[o] && buf_o[o*8 +: 8] !== exp_b[o]) bad++;
        check(q ? "R3 four-lane bytes" : "R2 one-lane bytes", 256'(bad), 256'd0);
        release_prog();
      end else begin
        check("R7 no busy", {255'd0, busy_o}, 256'd0);
      end
    end

    wel_i = 1'b1; wr_ok_i = 1'b1;
    // R7: partial byte at chip-select rise
    begin_op(8'h02, 24'h000000);
    send_byte(1'b0, 8'hA5);
    unit_vld_i = 1'b1; unit_i = 4'h1;
    repeat (3) @(negedge clk);
    unit_vld_i = 1'b0;
    end_op();
    check("R7 partial byte no commit", {255'd0, commit_o}, 256'd0);

    // R9: activity during busy is ignored
    begin_op(8'h02, 24'h00AA00);
    send_byte(1'b0, 8'hC3);
    end_op();
    check("R9 setup commit", {255'd0, commit_o}, 256'd1);
    pg_hold = page_o; m_hold = mask_o;
    begin_op(8'h32, 24'h112233);
    send_byte(1'b1, 8'h5E);
    end_op();
    check("R9 page held", {240'd0, page_o}, {240'd0, pg_hold});
    check("R9 mask held", mask_o, m_hold);
    check("R9 byte held", {248'd0, buf_o[7:0]}, 256'hC3);
    check("R9 no second commit", {255'd0, commit_o}, 256'd0);
    release_prog();

    // R6: restart clears mask and offset
    begin_op(8'h32, 24'h000050);
    send_byte(1'b1, 8'h12);
    send_byte(1'b1, 8'h34);
    begin_op(8'h32, 24'h000060);
    send_byte(1'b1, 8'h9E);
    end_op();
    check("R6 restart mask", mask_o, 256'd1 << 8'h60);
    check("R3 restart byte", {248'd0, buf_o[8'h60*8 +: 8]}, 256'h9E);
    release_prog();

    // R10: foreign opcode ends capture
    begin_op(8'h03, 24'h000070);
    send_byte(1'b0, 8'hFF);
    end_op();
    check("R10 no commit", {255'd0, commit_o}, 256'd0);
    check("R10 no busy", {255'd0, busy_o}, 256'd0);
    check("R10 mask empty", mask_o, 256'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule